// File: doc/BRIEF.md
# Regulator Channel Enable Controller

This block decides, for a single regulator channel, when the output stage is driven on. Software sets an enable bit and a pin-mode bit. With pin mode off the channel follows the bit alone. With pin mode on it follows an external enable pin, whose rising and falling edges are held back by separate 4-bit start-up and shutdown delay codes. The pin is resynchronised to the block clock before any edge is acted on. The channel is only ever driven while the device is in its standby or active state.

Once the stage is driven, the block watches a comparator that reports whether the output has climbed above a low short-circuit level. The comparator may stay low for too long, either right after turn-on or later while the channel runs. The block then drops the drive, emits a one-cycle short-circuit event, and locks the channel off. The lock is released by clearing the enable bit, or in pin mode by a fresh rising edge of the delayed pin. All time windows count a one-microsecond tick input, so the clock rate does not matter.

Top module: `regen_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `drive_en` and `sc_event` are 0.
- R2: `dev_state` is encoded 2'b00 off, 2'b01 standby, 2'b10 active, 2'b11 fault. Only standby and active allow drive. In any other state `drive_en` is 0 after the next clock edge.
- R3: With `reg_en` = 0 the channel is off whatever `pin_mode` and `en_pin` are.
- R4: With `reg_en` = 1 and `pin_mode` = 0 the channel is on and `en_pin` has no effect.
- R5: With `reg_en` = 1 and `pin_mode` = 1 the channel follows `en_pin` (high on, low off) through a two-flop synchroniser.
- R6: A rising pin level is accepted after `up_code` × STEP_TICKS counted ticks. With the tick held high, `drive_en` rises on the (4 + up_code·STEP_TICKS)-th clock edge after `en_pin` rises. A code of 0 means no added delay.
- R7: A falling pin level is accepted after `down_code` × STEP_TICKS ticks, with the same latency rule as R6.
- R8: A pin excursion that returns to its earlier level before its delay expires is discarded.
- R9: A change of `reg_en` reaches `drive_en` on the next clock edge, whatever the delay codes are.
- R10: After turn-on, if `above_thr` stays 0 for SC_LIMIT_TICKS ticks, `drive_en` falls and `sc_event` pulses high for exactly one cycle, on the same edge.
- R11: While the channel is on, a low spell of `above_thr` shorter than SC_LIMIT_TICKS ticks is forgiven. A low spell of SC_LIMIT_TICKS consecutive ticks trips as in R10.
- R12: After a trip the channel stays off until `reg_en` is seen at 0, or, in pin mode, until a new accepted rising pin level. In register mode pin activity does not release it.
- R13: The delay counters and the short-circuit window advance only on cycles where `us_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_state | input | 2 | Device state (encoding in R2) |
| reg_en | input | 1 | Register enable bit |
| pin_mode | input | 1 | 1 = channel follows the enable pin |
| en_pin | input | 1 | Asynchronous external enable pin |
| up_code | input | CODE_W | Start-up delay code for pin rising edges |
| down_code | input | CODE_W | Shutdown delay code for pin falling edges |
| us_tick | input | 1 | One-cycle microsecond tick |
| above_thr | input | 1 | Comparator: output above the short-circuit level (synchronous) |
| drive_en | output | 1 | Output stage enable |
| sc_event | output | 1 | One-cycle short-circuit shutdown pulse |

## Verification
Register and state inputs reach `drive_en` one edge after they change. A pin edge needs two synchroniser edges, one edge to be accepted with a zero code, one more for the output register, plus code × STEP_TICKS ticks. A short-circuit trip lands SC_LIMIT_TICKS ticks after the first low-comparator cycle in which the drive was already high. The bench drives all inputs on the falling clock edge and waits an exact count of rising edges before it samples. Each timed result is checked twice: low one edge before the computed edge, and settled on it. This pins the latency down rather than merely eventual behaviour.

// File: rtl/regen_pkg.sv
package regen_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'b00,
        ST_STANDBY = 2'b01,
        ST_ACTIVE  = 2'b10,
        ST_FAULT   = 2'b11
    } dev_state_e;

    // delayed pin as seen by the enable logic
    typedef struct packed {
        logic level;   // accepted pin level after its delay
        logic rise;    // one-cycle pulse when level is accepted high
    } pin_view_t;

    function automatic logic state_allows(input dev_state_e s);
        return (s == ST_STANDBY) || (s == ST_ACTIVE);
    endfunction

endpackage

// File: rtl/regen_pin_sync.sv
module regen_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/regen_edge_delay.sv
module regen_edge_delay
    import regen_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int STEP_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_s,
    input  logic [CODE_W-1:0] up_code,
    input  logic [CODE_W-1:0] down_code,
    input  logic              tick,
    output pin_view_t         view
);
    localparam int MAX_LIM = ((1 << CODE_W) - 1) * STEP_TICKS;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic             level;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // pending target is always the synchronised pin; its direction picks the code
    always_comb begin
        limit = (pin_s ? CNT_W'(up_code) : CNT_W'(down_code)) * CNT_W'(STEP_TICKS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            rise  <= 1'b0;
            cnt   <= '0;
        end else begin
            rise <= 1'b0;
            if (pin_s == level) begin
                cnt <= '0;                 // no change pending, or cancelled
            end else if (cnt >= limit) begin
                level <= pin_s;
                rise  <= pin_s;
                cnt   <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign view = '{level: level, rise: rise};

    assert_delay_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_LIM));

    // a level that agrees with the pin never changes on the next edge
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_s == level) |=> (level == $past(level)));

    assert_rise_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rise |-> level);
endmodule

// File: rtl/regen_sc_watch.sv
module regen_sc_watch #(
    parameter int LIMIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic drive_en,
    input  logic above_thr,
    input  logic tick,
    output logic trip
);
    localparam int CW = $clog2(LIMIT_TICKS + 1);

    logic [CW-1:0] low_cnt;

    // one window serves start-up and steady running: it counts low ticks while driven
    assign trip = drive_en && !above_thr && tick && (low_cnt == CW'(LIMIT_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!drive_en || above_thr) begin
            low_cnt <= '0;
        end else if (tick) begin
            low_cnt <= trip ? '0 : low_cnt + 1'b1;
        end
    end

    assert_window_bound_R11: assert property (@(posedge clk) disable iff (rst)
        low_cnt < CW'(LIMIT_TICKS));

    assert_window_clear_R11: assert property (@(posedge clk) disable iff (rst)
        above_thr |=> (low_cnt == '0));

    assert_tick_only_R13: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(low_cnt) || (low_cnt == '0));
endmodule

// File: rtl/regen_ctrl.sv
module regen_ctrl
    import regen_pkg::*;
#(
    parameter int CODE_W         = 4,
    parameter int STEP_TICKS     = 1000,
    parameter int SC_LIMIT_TICKS = 1000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dev_state,
    input  logic              reg_en,
    input  logic              pin_mode,
    input  logic              en_pin,
    input  logic [CODE_W-1:0] up_code,
    input  logic [CODE_W-1:0] down_code,
    input  logic              us_tick,
    input  logic              above_thr,
    output logic              drive_en,
    output logic              sc_event
);
    logic      pin_s;
    pin_view_t pin_v;
    logic      trip;
    logic      sc_lock;
    logic      lock_next;
    logic      want;
    logic      rearm;
    logic      st_ok;

    regen_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (en_pin),
        .dout (pin_s)
    );

    regen_edge_delay #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pin_s),
        .up_code   (up_code),
        .down_code (down_code),
        .tick      (us_tick),
        .view      (pin_v)
    );

    regen_sc_watch #(.LIMIT_TICKS(SC_LIMIT_TICKS)) u_watch (
        .clk       (clk),
        .rst       (rst),
        .drive_en  (drive_en),
        .above_thr (above_thr),
        .tick      (us_tick),
        .trip      (trip)
    );

    always_comb begin
        st_ok = state_allows(dev_state_e'(dev_state));
        want  = st_ok && reg_en && (!pin_mode || pin_v.level);
        rearm = pin_mode && pin_v.rise;
        if (trip)                 lock_next = 1'b1;
        else if (!reg_en || rearm) lock_next = 1'b0;
        else                       lock_next = sc_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_en <= 1'b0;
            sc_event <= 1'b0;
            sc_lock  <= 1'b0;
        end else begin
            drive_en <= want && !lock_next;
            sc_event <= trip;
            sc_lock  <= lock_next;
        end
    end

    assert_bad_state_off_R2: assert property (@(posedge clk) disable iff (rst)
        !st_ok |=> !drive_en);

    assert_no_enable_off_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_en |=> !drive_en);

    assert_sc_single_R10: assert property (@(posedge clk) disable iff (rst)
        sc_event |=> !sc_event);

    assert_sc_drops_drive_R10: assert property (@(posedge clk) disable iff (rst)
        sc_event |-> !drive_en);

    assert_lock_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (sc_lock && reg_en && !rearm) |=> !drive_en);
endmodule

// File: tb/tb_regen_ctrl.sv
module tb_regen_ctrl;
    localparam int CODE_W = 4;
    localparam int STEP   = 2;
    localparam int LIM    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] dev_state = 2'b10;
    logic reg_en = 1'b0, pin_mode = 1'b0, en_pin = 1'b0;
    logic [CODE_W-1:0] up_code = '0, down_code = '0;
    logic us_tick = 1'b1, above_thr = 1'b1;
    logic drive_en, sc_event;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;   // 250 MHz

    regen_ctrl #(.CODE_W(CODE_W), .STEP_TICKS(STEP), .SC_LIMIT_TICKS(LIM)) dut (
        .clk(clk), .rst(rst), .dev_state(dev_state), .reg_en(reg_en),
        .pin_mode(pin_mode), .en_pin(en_pin), .up_code(up_code),
        .down_code(down_code), .us_tick(us_tick), .above_thr(above_thr),
        .drive_en(drive_en), .sc_event(sc_event)
    );

    // {dev_state[1:0], reg_en, pin_mode, en_pin, expected drive_en}
    localparam logic [5:0] VEC [0:10] = '{
        6'b01_1_0_0_1,   // R4 pin low ignored
        6'b01_1_0_1_1,   // R4
        6'b10_1_1_1_1,   // R5 follows pin high
        6'b10_1_1_0_0,   // R5 follows pin low
        6'b10_0_1_1_0,   // R3
        6'b10_0_0_1_0,   // R3
        6'b00_1_0_0_0,   // R2 off state
        6'b11_1_1_1_0,   // R2 fault state
        6'b10_1_0_0_1,   // R4
        6'b01_1_1_1_1,   // R5 standby
        6'b11_1_0_0_0    // R2
    };

    function automatic string vec_tag(input logic [5:0] v);
        if (v[5:4] == 2'b00 || v[5:4] == 2'b11) return "R2";
        if (!v[3]) return "R3";
        if (!v[2]) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 drive in reset", drive_en, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 drive after reset", drive_en, 1'b0);
        chk("R1 sc after reset", sc_event, 1'b0);

        // table walk, comparator high, zero codes
        for (int i = 0; i <= 10; i++) begin
            {dev_state, reg_en, pin_mode, en_pin} = VEC[i][5:1];
            step(6);
            chk(vec_tag(VEC[i]), drive_en, VEC[i][0]);
        end

        // R6 / R7 pin delays
        dev_state = 2'b10; reg_en = 1'b1; pin_mode = 1'b1; en_pin = 1'b0;
        up_code = 4'd3; down_code = 4'd2;
        step(8);
        chk("R6 idle low", drive_en, 1'b0);
        en_pin = 1'b1;
        step(3 + 3 * STEP);
        chk("R6 one edge early", drive_en, 1'b0);
        step(1);
        chk("R6 on time", drive_en, 1'b1);
        en_pin = 1'b0;
        step(3 + 2 * STEP);
        chk("R7 one edge early", drive_en, 1'b1);
        step(1);
        chk("R7 on time", drive_en, 1'b0);

        // R8 cancellation both ways
        en_pin = 1'b1; step(5); en_pin = 1'b0; step(25);
        chk("R8 short high discarded", drive_en, 1'b0);
        en_pin = 1'b1; step(20);
        chk("R8 setup high", drive_en, 1'b1);
        en_pin = 1'b0; step(3); en_pin = 1'b1; step(25);
        chk("R8 short low discarded", drive_en, 1'b1);

        // R9 register writes are immediate despite codes
        pin_mode = 1'b0; reg_en = 1'b0;
        step(1);
        chk("R9 clear immediate", drive_en, 1'b0);
        reg_en = 1'b1;
        step(1);
        chk("R9 set immediate", drive_en, 1'b1);

        // R10 start-up timeout
        reg_en = 1'b0; step(2);
        above_thr = 1'b0; reg_en = 1'b1;
        step(LIM);
        chk("R10 still on", drive_en, 1'b1);
        chk("R10 no event yet", sc_event, 1'b0);
        step(1);
        chk("R10 tripped", drive_en, 1'b0);
        chk("R10 event", sc_event, 1'b1);
        step(1);
        chk("R10 event one cycle", sc_event, 1'b0);

        // R12 lock in register mode, pin ignored
        above_thr = 1'b1;
        en_pin = 1'b0; step(8); en_pin = 1'b1; step(8);
        chk("R12 locked despite pin", drive_en, 1'b0);
        reg_en = 1'b0; step(2);
        reg_en = 1'b1; step(1);
        chk("R12 released by enable toggle", drive_en, 1'b1);

        // R11 steady-state
        above_thr = 1'b0; step(LIM - 2);
        above_thr = 1'b1; step(20);
        chk("R11 short dip forgiven", drive_en, 1'b1);
        above_thr = 1'b0;
        step(LIM - 1);
        chk("R11 still on", drive_en, 1'b1);
        step(1);
        chk("R11 tripped", drive_en, 1'b0);
        chk("R11 event", sc_event, 1'b1);

        // R13 window frozen without ticks
        reg_en = 1'b0; step(2);
        us_tick = 1'b0; reg_en = 1'b1;
        step(3 * LIM);
        chk("R13 no trip without tick", drive_en, 1'b1);
        us_tick = 1'b1;
        step(LIM - 1);
        chk("R13 still on", drive_en, 1'b1);
        step(1);
        chk("R13 trips after ticks", drive_en, 1'b0);

        // R12 pin-mode release by new rising edge
        reg_en = 1'b0; above_thr = 1'b1; step(2);
        pin_mode = 1'b1; up_code = '0; down_code = '0; en_pin = 1'b1; step(6);
        above_thr = 1'b0; reg_en = 1'b1;
        step(LIM + 6);
        chk("R12 pin mode tripped", drive_en, 1'b0);
        en_pin = 1'b0; step(6);
        chk("R12 still locked", drive_en, 1'b0);
        above_thr = 1'b1; en_pin = 1'b1;
        step(3);
        chk("R5 sync latency early", drive_en, 1'b0);
        step(1);
        chk("R12 released by rising pin", drive_en, 1'b1);

        // R2 state change while running
        dev_state = 2'b11; step(1);
        chk("R2 fault drops drive", drive_en, 1'b0);
        dev_state = 2'b01; step(1);
        chk("R2 standby restores", drive_en, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule